// File: doc/BRIEF.md
# Interrupt Line State Register Bank

This block is the software-visible state store of a 68-line interrupt controller. For every line it keeps three flags: whether the line is enabled, whether a request is waiting, and whether the line's handler is running. It also keeps a 4-bit priority for every line. Software reaches this state over a simple 32-bit bus with word addresses, a write strobe and a read strobe. The flags are packed 32 lines to a word. The priorities are packed four lines to a word, one byte per line.

The enable and pending flags each have two write addresses. One sets flags and the other clears them. In both, a 1 in the data acts on that line and a 0 leaves it alone. Software can therefore change a single line without first reading the word. Peripherals raise pending flags directly with one-cycle pulses. The priority resolver sets and clears the active flags through its own inputs.

Every flag vector and every priority field is exported in full, so the resolver can act on them in the same cycle.

Top module: `irq_reg_bank`

## Requirements
- R1: Address map (word address, 6 bits). Bit 5 clear selects a flag group with bits [4:2] and a word with bits [1:0]: group 0 is enable-set, 1 is enable-clear, 2 is pending-set, 3 is pending-clear, 4 is active. Line n sits at bit n%32 of flag word n/32 in every flag group.
- R2: Writing the enable-set group sets the enable of every line whose data bit is 1. Lines whose data bit is 0 keep their enable.
- R3: Writing the enable-clear group clears the enable of every line whose data bit is 1. Other lines are unchanged.
- R4: The pending-set and pending-clear groups set and clear pending flags with the same write-1 rule.
- R5: Reading either the set word or the clear word of a group returns the current flag vector.
- R6: An active-set input raises that line's active flag, and an active-clear input lowers it. When both reach the same line in one cycle, the flag ends up set.
- R7: The active group is read-only. Bus writes to it change nothing.
- R8: Addresses 0x20+m hold priority word m, for m from 0 to 16. Line 4m+k uses byte k. Bits [7:4] of that byte are stored as the line's 4-bit priority, and the priority appears on irq_prio[4n+3:4n].
- R9: Bits [3:0] of every priority byte read as zero, and writes to them are dropped.
- R10: Bits for lines 68 to 95 in flag word 2 read as zero and ignore writes. Unused addresses (flag word 3, groups 5 to 7, priority words 17 to 31) read as zero and ignore writes.
- R11: If a hardware pending pulse and a software pending-clear reach the same line in one cycle, the line ends up pending.
- R12: After reset, all enable, pending, active and priority state is zero.
- R13: bus_rdata is loaded in the cycle after a read strobe, from state as it was at that strobe's clock edge. It holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Word address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_pend_set | input | 68 | Per-line pending pulses from peripherals |
| act_set | input | 68 | Per-line active-set from resolver |
| act_clr | input | 68 | Per-line active-clear from resolver |
| irq_enable | output | 68 | Enable vector |
| irq_pending | output | 68 | Pending vector |
| irq_active | output | 68 | Active vector |
| irq_prio | output | 272 | Four-bit priority per line, line n at [4n+3:4n] |

## Verification
The assertions check, on every cycle, the rules for each flag update. A set input dominates a clear input, a clear with no set drops the flag, and a vector with no stimulus holds its value. They also check that priorities change only on a priority write and take the written upper nibble, that priority low nibbles and the tail bits of word 2 read as zero, that the active vector ignores bus writes, and that read data holds between reads. Only the bench scenarios can show the address decode end to end. That covers the mapping of a line to a word and bit, aliased reads returning the same state, and unused addresses reading zero. The scenarios are a reference model driven by mixed random and directed traffic, including a simultaneous hardware pulse and pending-clear write.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        GRP_EN_SET = 3'd0,
        GRP_EN_CLR = 3'd1,
        GRP_PD_SET = 3'd2,
        GRP_PD_CLR = 3'd3,
        GRP_ACT    = 3'd4,
        GRP_PRIO   = 3'd5,
        GRP_NONE   = 3'd6
    } grp_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_bank_pkg::*;
#(
    parameter int LINES = 68
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output grp_e              grp,
    output logic [1:0]        wsel,
    output logic [4:0]        psel,
    output logic              hit,
    output logic [LINES-1:0]  en_set,
    output logic [LINES-1:0]  en_clr,
    output logic [LINES-1:0]  pd_set,
    output logic [LINES-1:0]  pd_clr,
    output logic [((LINES+3)/4)-1:0] prio_we
);
    localparam int WORDS  = (LINES + 31) / 32;
    localparam int PWORDS = (LINES + 3) / 4;

    logic [LINES-1:0] line_hit;

    always_comb begin
        grp  = GRP_NONE;
        wsel = addr[1:0];
        psel = addr[4:0];
        hit  = 1'b0;
        if (addr[5]) begin
            grp = GRP_PRIO;
            hit = (int'(psel) < PWORDS);
        end else begin
            case (addr[4:2])
                3'd0:    grp = GRP_EN_SET;
                3'd1:    grp = GRP_EN_CLR;
                3'd2:    grp = GRP_PD_SET;
                3'd3:    grp = GRP_PD_CLR;
                3'd4:    grp = GRP_ACT;
                default: grp = GRP_NONE;
            endcase
            hit = (grp != GRP_NONE) && (int'(wsel) < WORDS);
        end
    end

    for (genvar n = 0; n < LINES; n++) begin : g_line
        localparam int WIDX = n / 32;
        localparam int BIDX = n % 32;
        assign line_hit[n] = wr_en && hit && !addr[5] && (wsel == 2'(WIDX)) && wdata[BIDX];
        assign en_set[n]   = line_hit[n] && (grp == GRP_EN_SET);
        assign en_clr[n]   = line_hit[n] && (grp == GRP_EN_CLR);
        assign pd_set[n]   = line_hit[n] && (grp == GRP_PD_SET);
        assign pd_clr[n]   = line_hit[n] && (grp == GRP_PD_CLR);
    end

    for (genvar m = 0; m < PWORDS; m++) begin : g_pword
        assign prio_we[m] = wr_en && hit && (grp == GRP_PRIO) && (psel == 5'(m));
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 68
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] hw_clr,
    output logic [N-1:0] flags
);
    typedef struct packed {
        logic [N-1:0] bits;
    } flag_s;

    flag_s st_d, st_q;
    logic [N-1:0] any_set, any_clr;

    assign any_set = sw_set | hw_set;
    assign any_clr = sw_clr | hw_clr;

    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~any_clr) | any_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.bits;

    // Set dominates clear in the same cycle (R11 for pending, R6 for active)
    p_set_dominates_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (any_set != '0) |=> ((st_q.bits & $past(any_set)) == $past(any_set)));

    p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((any_clr & ~any_set) != '0) |=> ((st_q.bits & $past(any_clr & ~any_set)) == '0));

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((any_set | any_clr) == '0) |=> $stable(st_q.bits));
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
    import irq_bank_pkg::*;
#(
    parameter int LINES = 68
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [((LINES+3)/4)-1:0]  we,
    input  logic [DATA_W-1:0]         wdata,
    output logic [LINES*4-1:0]        prio
);
    typedef struct packed {
        logic [LINES-1:0][3:0] nib;
    } prio_s;

    prio_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int n = 0; n < LINES; n++) begin
            if (we[n / 4]) st_d.nib[n] = wdata[(n % 4) * 8 + 4 +: 4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prio = st_q;

    p_prio_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we == '0) |=> $stable(st_q));

    for (genvar n = 0; n < LINES; n++) begin : g_chk
        p_prio_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
            we[n / 4] |=> (st_q.nib[n] == $past(wdata[(n % 4) * 8 + 4 +: 4])));
    end
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
    import irq_bank_pkg::*;
#(
    parameter int LINES = 68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [LINES-1:0]  hw_pend_set,
    input  logic [LINES-1:0]  act_set,
    input  logic [LINES-1:0]  act_clr,
    output logic [LINES-1:0]  irq_enable,
    output logic [LINES-1:0]  irq_pending,
    output logic [LINES-1:0]  irq_active,
    output logic [LINES*4-1:0] irq_prio
);
    localparam int WORDS     = (LINES + 31) / 32;
    localparam int PWORDS    = (LINES + 3) / 4;
    localparam int PAD       = WORDS * 32;
    localparam int TAIL_BITS = LINES - (WORDS - 1) * 32;
    localparam logic [31:0] TAIL_MASK =
        (TAIL_BITS == 32) ? 32'h0 : ~((32'h1 << TAIL_BITS) - 32'h1);

    typedef struct packed {
        logic [31:0] rdata;
    } rd_s;

    grp_e              grp;
    logic [1:0]        wsel;
    logic [4:0]        psel;
    logic              hit;
    logic [LINES-1:0]  en_set, en_clr, pd_set, pd_clr;
    logic [PWORDS-1:0] prio_we;
    logic [WORDS-1:0][31:0] en_w, pd_w, act_w;
    logic [31:0]       rd_word;
    rd_s               rd_d, rd_q;

    irq_bus_decode #(.LINES(LINES)) u_dec (
        .addr    (bus_addr),
        .wr_en   (bus_wr),
        .wdata   (bus_wdata),
        .grp     (grp),
        .wsel    (wsel),
        .psel    (psel),
        .hit     (hit),
        .en_set  (en_set),
        .en_clr  (en_clr),
        .pd_set  (pd_set),
        .pd_clr  (pd_clr),
        .prio_we (prio_we)
    );

    irq_flag_bank #(.N(LINES)) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set (en_set),
        .sw_clr (en_clr),
        .hw_set ('0),
        .hw_clr ('0),
        .flags  (irq_enable)
    );

    irq_flag_bank #(.N(LINES)) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set (pd_set),
        .sw_clr (pd_clr),
        .hw_set (hw_pend_set),
        .hw_clr ('0),
        .flags  (irq_pending)
    );

    irq_flag_bank #(.N(LINES)) u_active (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set ('0),
        .sw_clr ('0),
        .hw_set (act_set),
        .hw_clr (act_clr),
        .flags  (irq_active)
    );

    irq_prio_bank #(.LINES(LINES)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (prio_we),
        .wdata (bus_wdata),
        .prio  (irq_prio)
    );

    assign en_w  = PAD'(irq_enable);
    assign pd_w  = PAD'(irq_pending);
    assign act_w = PAD'(irq_active);

    always_comb begin
        rd_word = '0;
        if (hit) begin
            case (grp)
                GRP_EN_SET, GRP_EN_CLR: rd_word = en_w[wsel];
                GRP_PD_SET, GRP_PD_CLR: rd_word = pd_w[wsel];
                GRP_ACT:                rd_word = act_w[wsel];
                GRP_PRIO: begin
                    for (int k = 0; k < 4; k++) begin
                        if (int'(psel) * 4 + k < LINES)
                            rd_word[k * 8 + 4 +: 4] = irq_prio[(int'(psel) * 4 + k) * 4 +: 4];
                    end
                end
                default: rd_word = '0;
            endcase
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) rd_d.rdata = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    p_prio_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[5]) |=> ((bus_rdata & 32'h0F0F_0F0F) == 32'h0));

    p_tail_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr[5] && (int'(bus_addr[1:0]) == WORDS - 1))
        |=> ((bus_rdata & TAIL_MASK) == 32'h0));

    p_active_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (grp == GRP_ACT) && (act_set == '0) && (act_clr == '0))
        |=> $stable(irq_active));
endmodule

// File: tb/irq_reg_bank_bench.sv
module irq_reg_bank_bench;
    localparam int L = 68;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [L-1:0]  hw_pend_set = '0, act_set = '0, act_clr = '0;
    logic [L-1:0]  irq_enable, irq_pending, irq_active;
    logic [L*4-1:0] irq_prio;

    int checks = 0;
    int failures = 0;

    logic [L-1:0]  m_en = '0, m_pd = '0, m_act = '0;
    logic [L*4-1:0] m_prio = '0;
    logic [31:0]   m_rd = '0;

    always #2 clk = ~clk;

    irq_reg_bank u_irq_reg_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_pend_set(hw_pend_set), .act_set(act_set), .act_clr(act_clr),
        .irq_enable(irq_enable), .irq_pending(irq_pending),
        .irq_active(irq_active), .irq_prio(irq_prio)
    );

    function automatic logic [L-1:0] expand(input int w, input logic [31:0] d);
        logic [L-1:0] v = '0;
        for (int n = 0; n < L; n++) if (n / 32 == w) v[n] = d[n % 32];
        return v;
    endfunction

    function automatic logic [31:0] model_read(input logic [5:0] a);
        logic [31:0] r = '0;
        logic [L-1:0] vec;
        int w;
        if (a[5]) begin
            for (int k = 0; k < 4; k++)
                if (int'(a[4:0]) * 4 + k < L)
                    r[k * 8 + 4 +: 4] = m_prio[(int'(a[4:0]) * 4 + k) * 4 +: 4];
        end else begin
            w = int'(a[1:0]);
            case (a[4:2])
                3'd0, 3'd1: vec = m_en;
                3'd2, 3'd3: vec = m_pd;
                3'd4:       vec = m_act;
                default:    vec = '0;
            endcase
            for (int b = 0; b < 32; b++)
                if (w * 32 + b < L) r[b] = vec[w * 32 + b];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [L*4-1:0] act, input logic [L*4-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one bus cycle at a negedge, update the model, sample at the next negedge.
    task automatic cyc(input logic wr, input logic rd, input logic [5:0] a, input logic [31:0] d,
                       input logic [L-1:0] hp, input logic [L-1:0] as, input logic [L-1:0] ac,
                       input string req);
        logic [L-1:0] mk;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        hw_pend_set = hp; act_set = as; act_clr = ac;
        if (rd) m_rd = model_read(a);
        mk = expand(int'(a[1:0]), d);
        if (wr && a[5]) begin
            for (int k = 0; k < 4; k++)
                if (int'(a[4:0]) * 4 + k < L)
                    m_prio[(int'(a[4:0]) * 4 + k) * 4 +: 4] = d[k * 8 + 4 +: 4];
        end else if (wr) begin
            case (a[4:2])
                3'd0: m_en = m_en | mk;
                3'd1: m_en = m_en & ~mk;
                3'd2: m_pd = m_pd | mk;
                3'd3: m_pd = m_pd & ~mk;
                default: ;
            endcase
        end
        m_pd  = m_pd | hp;
        m_act = (m_act & ~ac) | as;
        @(posedge clk);
        @(negedge clk);
        check({req, " enable"},  (L*4)'(irq_enable),  (L*4)'(m_en));
        check({req, " pending"}, (L*4)'(irq_pending), (L*4)'(m_pd));
        check({req, " active"},  (L*4)'(irq_active),  (L*4)'(m_act));
        check({req, " prio"},    irq_prio, m_prio);
        check({req, " rdata"},   (L*4)'(bus_rdata), (L*4)'(m_rd));
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input string req);
        cyc(1'b1, 1'b0, a, d, '0, '0, '0, req);
    endtask

    task automatic rd(input logic [5:0] a, input string req);
        cyc(1'b0, 1'b1, a, 32'h0, '0, '0, '0, req);
    endtask

    function automatic logic [L-1:0] sparse();
        logic [95:0] r = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
                       & {$urandom, $urandom, $urandom};
        return r[L-1:0];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 reset enable", (L*4)'(irq_enable), '0);
        check("R12 reset prio", irq_prio, '0);
        check("R12 reset rdata", (L*4)'(bus_rdata), '0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(6'h00, "R12");

        // R2: set-enable, zeros leave lines untouched
        wr(6'h00, 32'h8000_0001, "R2");
        wr(6'h00, 32'h0000_0000, "R2");
        check("R2 line31", (L*4)'(irq_enable[31]), (L*4)'(1'b1));
        // R1: line 33 at bit 1 of word 1
        wr(6'h01, 32'h0000_0002, "R1");
        check("R1 line33", (L*4)'(irq_enable[33]), (L*4)'(1'b1));
        // R3: clear-enable
        wr(6'h04, 32'h0000_0001, "R3");
        check("R3 line0", (L*4)'(irq_enable[0]), '0);
        // R5: both aliases read the same state
        rd(6'h05, "R5");
        check("R5 clr alias", (L*4)'(bus_rdata), (L*4)'(32'h2));
        rd(6'h00, "R5");
        // R4: pending set and clear
        wr(6'h0A, 32'h0000_000F, "R4");
        wr(6'h0E, 32'h0000_0005, "R4");
        check("R4 pending word2", (L*4)'(irq_pending[67:64]), (L*4)'(4'hA));
        // R10: tail bits and unused words
        wr(6'h02, 32'hFFFF_FFFF, "R10");
        rd(6'h02, "R10");
        check("R10 tail", (L*4)'(bus_rdata), (L*4)'(32'hF));
        wr(6'h03, 32'hFFFF_FFFF, "R10");
        rd(6'h03, "R10");
        wr(6'h31, 32'hFFFF_FFFF, "R10");
        rd(6'h31, "R10");
        wr(6'h18, 32'hFFFF_FFFF, "R10");
        rd(6'h18, "R10");
        // R6: resolver updates, set wins over clear
        cyc(1'b0, 1'b0, 6'h0, 32'h0, '0, L'(1) << 40, L'(1) << 40, "R6");
        check("R6 set wins", (L*4)'(irq_active[40]), (L*4)'(1'b1));
        cyc(1'b0, 1'b0, 6'h0, 32'h0, '0, '0, L'(1) << 40, "R6");
        // R7: active words ignore bus writes
        wr(6'h11, 32'hFFFF_FFFF, "R7");
        check("R7 active", (L*4)'(irq_active), '0);
        // R8 / R9: priority packing and low nibble
        wr(6'h21, 32'h4F3E_2D1C, "R8");
        check("R8 line4", (L*4)'(irq_prio[4*4 +: 4]), (L*4)'(4'h1));
        check("R8 line7", (L*4)'(irq_prio[7*4 +: 4]), (L*4)'(4'h4));
        rd(6'h21, "R9");
        check("R9 readback", (L*4)'(bus_rdata), (L*4)'(32'h4030_2010));
        wr(6'h30, 32'hA0B0_C0D0, "R8");
        rd(6'h30, "R8");
        // R11: hardware pulse beats same-cycle clear
        cyc(1'b1, 1'b0, 6'h0D, 32'h0000_0200, L'(1) << 41, '0, '0, "R11");
        check("R11 line41", (L*4)'(irq_pending[41]), (L*4)'(1'b1));
        // R13: rdata holds without a read
        wr(6'h00, 32'hFFFF_FFFF, "R13");
        check("R13 hold", (L*4)'(bus_rdata), (L*4)'(32'hA0B0_C0D0));

        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 2) == 0, ($urandom % 2) == 0, 6'($urandom), $urandom,
                sparse(), sparse(), sparse(), "R1 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule